// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. A trigger starts a binary search over a 10-bit trial register. The register contents are driven out as the code of an internal comparison voltage. A one-bit comparator input reports whether the analog input lies above that voltage. One bit is resolved per clock, from the most significant bit downward.

A mode input chooses between a full 10-bit search and a shorter 8-bit search. The short search stops after bit 2 and leaves the two lowest bits at zero. When the last bit of the active mode is resolved, the word is stored in one of eight per-channel result registers. The channel is the one selected at trigger time. A one-cycle done pulse marks the write. The result registers can be read at any time through a combinational read port.

Each comparison-voltage code n from 1 to 1023 stands for a level of (n - 0.5) reference steps, where one step is 1/1024 of the reference. Code 0 stands for 0 V. A search driven by a correct comparator therefore returns the largest code whose level lies below the input.

Top module: `sar_conv_ctrl`

## Requirements
- R1: When `start_i` is high at a clock edge while `busy_o` is low, the conversion is accepted. From that edge on, `dac_code_o` is 10'b10_0000_0000 and `busy_o` is high.
- R2: At each clock edge during a conversion, `comp_i` is sampled for the current trial bit. A 1 (input above the trial level) keeps the bit and a 0 clears it. Unless the bit is the last of the mode, the next lower bit is set to 1 at the same edge. `dac_code_o` always shows the register.
- R3: In full mode (`short_mode_i` = 0 at acceptance), bits 9 down to 0 are tried. The result is written at the 10th edge after acceptance. It equals the largest code n whose level (n - 0.5) steps lies below the input, or 0 when no such code exists.
- R4: In short mode (`short_mode_i` = 1 at acceptance), only bits 9 down to 2 are tried. The result is written at the 8th edge after acceptance, with bits 1 and 0 equal to 0.
- R5: The result goes only to the register of the channel given on `chan_i` at acceptance, and the other channels keep their values. `rd_data_o` shows the register selected by `rd_chan_i` in the same cycle.
- R6: `done_o` is high for exactly the one cycle after the edge that writes the result. `busy_o` falls at that same edge.
- R7: A trigger that arrives while `busy_o` is high is ignored. The running conversion keeps its timing, its mode and its channel.
- R8: A synchronous active-low reset clears the trial register, all result registers, `busy_o` and `done_o`. This also applies in the middle of a conversion.
- R9: Because code 0 stands for 0 V and code n for (n - 0.5) steps, an input at or below half a step converts to 0. An input above 1022.5 steps converts to 1023 in full mode and to 1020 in short mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion trigger, sampled at each edge |
| short_mode_i | input | 1 | 1 selects the 8-bit search, 0 the 10-bit search; latched at acceptance |
| chan_i | input | 3 | Channel whose result register receives the result; latched at acceptance |
| comp_i | input | 1 | Comparator: 1 when the analog input is above the level of `dac_code_o` |
| dac_code_o | output | 10 | Trial register, code of the comparison voltage |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse after a result is written |
| rd_chan_i | input | 3 | Result register to read |
| rd_data_o | output | 10 | Contents of the selected result register |

## Verification
The assertions check on every cycle the invariants of the sequence. These are: the loaded initial code, the bits below the trial bit staying zero, the done pulse lasting one cycle with busy dropping together with it, the channel and mode staying fixed during a run, at most one result register written per edge, and short-mode results carrying zero low bits. Only the bench's scenarios can show that the search lands on the right code for a given input. To show this, the bench models the comparator from the half-step level convention and compares the trial code after every edge. The scenarios also show that results reach the right channel, that input extremes behave as stated, and that triggers during a run and a mid-run reset act as required.

// File: rtl/sar_conv_pkg.sv
// Package: shared types of the successive approximation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_conv_pkg;

    // Search length selected at acceptance.
    typedef enum logic {
        MODE_FULL  = 1'b0,
        MODE_SHORT = 1'b1
    } sar_mode_e;

endpackage

// File: rtl/sar_step_seq.sv
// Module: sar_step_seq
// Sequences one conversion. It accepts a trigger only while idle, latches the
// mode and channel, walks the trial bit index downward one bit per clock, and
// flags the last bit of the active mode. It raises done for one cycle after
// the last bit is resolved.
// Assumes: STOP_SHORT < WIDTH; the trial register and the result bank are
// driven from load_o/step_o/last_o in the same cycle.
module sar_step_seq
    import sar_conv_pkg::*;
#(
    parameter int WIDTH      = 10,
    parameter int STOP_SHORT = 2,
    parameter int CH_W       = 3,
    localparam int IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  sar_mode_e        mode_i,
    input  logic [CH_W-1:0]  chan_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic [IDX_W-1:0] bit_o,
    output sar_mode_e        mode_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(WIDTH - 1);
    localparam logic [IDX_W-1:0] SHORT_IDX = IDX_W'(STOP_SHORT);

    logic             busy_q;
    logic             done_q;
    logic [IDX_W-1:0] bit_q;
    sar_mode_e        mode_q;
    logic [CH_W-1:0]  chan_q;
    logic [IDX_W-1:0] stop_idx;

    // Purpose: pick the lowest trial bit of the latched mode.
    always_comb begin
        stop_idx = (mode_q == MODE_SHORT) ? SHORT_IDX : '0;
    end

    // Purpose: decode acceptance, stepping and the last step.
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
        last_o = busy_q && (bit_q == stop_idx);
    end

    // Purpose: busy state, trial index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            bit_q  <= '0;
        end else begin
            done_q <= last_o;
            if (load_o) begin
                busy_q <= 1'b1;
                bit_q  <= TOP_IDX;
            end else if (last_o) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                bit_q  <= bit_q - 1'b1;
            end
        end
    end

    // Purpose: latch mode and channel at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FULL;
            chan_q <= '0;
        end else if (load_o) begin
            mode_q <= mode_i;
            chan_q <= chan_i;
        end
    end

    assign bit_o  = bit_q;
    assign mode_o = mode_q;
    assign chan_o = chan_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // R6: done lasts one cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6: the last step ends busy and raises done.
    a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (!busy_q && done_q));
    // R7: channel and mode hold while a run continues.
    a_r7_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_o) |=> (chan_q == $past(chan_q) && mode_q == $past(mode_q) && busy_q));

endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// Holds the successive approximation word. On load it sets only the top bit.
// On each step it writes the comparator into the trial bit and, unless this
// is the last step, sets the next lower bit. It presents the resolved word as
// the result, with the low bits forced to zero in short mode.
// Assumes: bit_i > 0 whenever step_i is high and last_i is low.
module sar_trial_reg
    import sar_conv_pkg::*;
#(
    parameter int WIDTH      = 10,
    parameter int STOP_SHORT = 2,
    localparam int IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             last_i,
    input  logic [IDX_W-1:0] bit_i,
    input  sar_mode_e        mode_i,
    input  logic             comp_i,
    output logic [WIDTH-1:0] code_o,
    output logic [WIDTH-1:0] result_o
);

    localparam logic [WIDTH-1:0] INIT_WORD = WIDTH'(1) << (WIDTH - 1);
    localparam logic [WIDTH-1:0] LOW_MASK  = (WIDTH'(1) << STOP_SHORT) - WIDTH'(1);

    logic [WIDTH-1:0] sar_q;
    logic [WIDTH-1:0] sar_d;

    // Purpose: next trial word from load, comparison and next trial bit.
    always_comb begin
        sar_d = sar_q;
        if (load_i) begin
            sar_d = INIT_WORD;
        end else if (step_i) begin
            sar_d[bit_i] = comp_i;
            if (!last_i) begin
                sar_d[bit_i - 1'b1] = 1'b1;
            end
        end
    end

    // Purpose: resolved word for the result bank, masked in short mode.
    always_comb begin
        result_o = (mode_i == MODE_SHORT) ? (sar_d & ~LOW_MASK) : sar_d;
    end

    // Purpose: trial word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
        end else begin
            sar_q <= sar_d;
        end
    end

    assign code_o = sar_q;

    // R1: an accepted trigger starts from the top bit alone.
    a_r1_init_word: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (code_o == INIT_WORD));
    // R2: bits below the current trial bit are still zero.
    a_r2_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> ((sar_q & ((WIDTH'(1) << bit_i) - WIDTH'(1))) == '0));
    // R2: the trial bit is set while it waits for its comparison.
    a_r2_trial_set: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> sar_q[bit_i]);

endmodule

// File: rtl/sar_result_bank.sv
// Module: sar_result_bank
// One result register per channel. A write lands only in the addressed
// register. The read port is a combinational multiplexer.
// Assumes: at most one write per cycle.
module sar_result_bank
    import sar_conv_pkg::*;
#(
    parameter int WIDTH      = 10,
    parameter int NUM_CH     = 8,
    parameter int STOP_SHORT = 2,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  sar_mode_e        wr_mode_i,
    input  logic [CH_W-1:0]  rd_chan_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0]  res_q [NUM_CH];
    logic [NUM_CH-1:0] we;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        // Purpose: write enable of this channel.
        assign we[ch] = wr_en_i && (wr_chan_i == CH_W'(ch));

        // Purpose: result register of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[ch] <= '0;
            end else if (we[ch]) begin
                res_q[ch] <= wr_data_i;
            end
        end
    end

    // Purpose: read multiplexer.
    always_comb begin
        rd_data_o = res_q[rd_chan_i];
    end

    // R5: no more than one register written per edge.
    a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
    // R4: short-mode results arrive with zero low bits.
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_mode_i == MODE_SHORT) |-> (wr_data_i[STOP_SHORT-1:0] == '0));

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: sar_conv_ctrl (top)
// Successive approximation conversion controller: the step sequencer, the
// trial register and the per-channel result bank.
// Assumes: the comparator output is valid one clock after dac_code_o changes.
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int WIDTH      = 10,
    parameter int NUM_CH     = 8,
    parameter int STOP_SHORT = 2,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_mode_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             comp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    input  logic [CH_W-1:0]  rd_chan_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic             load;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] bit_idx;
    sar_mode_e        mode_run;
    logic [CH_W-1:0]  chan_run;
    logic [WIDTH-1:0] result;

    sar_step_seq #(
        .WIDTH      (WIDTH),
        .STOP_SHORT (STOP_SHORT),
        .CH_W       (CH_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (sar_mode_e'(short_mode_i)),
        .chan_i  (chan_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .bit_o   (bit_idx),
        .mode_o  (mode_run),
        .chan_o  (chan_run),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sar_trial_reg #(
        .WIDTH      (WIDTH),
        .STOP_SHORT (STOP_SHORT)
    ) u_trial (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .last_i   (last),
        .bit_i    (bit_idx),
        .mode_i   (mode_run),
        .comp_i   (comp_i),
        .code_o   (dac_code_o),
        .result_o (result)
    );

    sar_result_bank #(
        .WIDTH      (WIDTH),
        .NUM_CH     (NUM_CH),
        .STOP_SHORT (STOP_SHORT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (last),
        .wr_chan_i (chan_run),
        .wr_data_i (result),
        .wr_mode_i (mode_run),
        .rd_chan_i (rd_chan_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: tb/sar_conv_ctrl_test.sv
// Directed bench: the comparator is modelled from the half-step level rule,
// with the input held in half-step units.
module sar_conv_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       short_mode = 1'b0;
    logic [2:0] chan = '0;
    logic [2:0] rd_chan = '0;
    logic       comp;
    logic [9:0] dac_code;
    logic       busy;
    logic       done;
    logic [9:0] rd_data;

    int vin_h = 0;
    int checks = 0;
    int errors = 0;
    int model [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Comparator: code 0 is 0 V, code n is (2n-1) half steps.
    assign comp = (vin_h > ((dac_code == 10'd0) ? 0 : (2 * int'(dac_code) - 1)));

    sar_conv_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .short_mode_i (short_mode),
        .chan_i       (chan),
        .comp_i       (comp),
        .dac_code_o   (dac_code),
        .busy_o       (busy),
        .done_o       (done),
        .rd_chan_i    (rd_chan),
        .rd_data_o    (rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expected(input int v, input bit sh);
        int r = v / 2;
        if (r > 1023) r = 1023;
        if (sh) r = r & ~3;
        return r;
    endfunction

    task automatic check_all_channels(input string req);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            rd_chan = 3'(c);
            #1;
            check(int'(rd_data) == model[c], req, int'(rd_data), model[c]);
        end
    endtask

    // R8: reset state.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) model[c] = 0;
        check(busy == 1'b0, "R8 busy", int'(busy), 0);
        check(done == 1'b0, "R8 done", int'(done), 0);
        check(dac_code == 10'd0, "R8 code", int'(dac_code), 0);
        check_all_channels("R8 result cleared");
    endtask

    // R1 R2 R3 R4 R6 R7: one conversion, optionally poked mid-run.
    task automatic t_convert(input int v, input bit sh, input int ch, input bit poke);
        int nbits = sh ? 8 : 10;
        int exp = expected(v, sh);
        int want;
        @(negedge clk);
        vin_h = v;
        short_mode = sh;
        chan = 3'(ch);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(int'(dac_code) == 512, "R1 initial code", int'(dac_code), 512);
        check(busy == 1'b1, "R1 busy", int'(busy), 1);
        for (int k = 1; k < nbits; k++) begin
            if (poke && k == 3) begin
                start = 1'b1;
                chan = 3'(ch ^ 1);
                short_mode = ~sh;
            end
            @(negedge clk);
            start = 1'b0;
            want = (exp & (((1 << k) - 1) << (10 - k))) | (1 << (9 - k));
            check(int'(dac_code) == want, poke ? "R7 trial code" : "R2 trial code",
                  int'(dac_code), want);
            check(done == 1'b0, "R6 done early", int'(done), 0);
        end
        @(negedge clk);
        model[ch] = exp;
        rd_chan = 3'(ch);
        #1;
        check(done == 1'b1, "R6 done", int'(done), 1);
        check(busy == 1'b0, "R6 busy", int'(busy), 0);
        check(int'(rd_data) == exp, sh ? "R4 result" : "R3 result", int'(rd_data), exp);
        @(negedge clk);
        check(done == 1'b0, "R6 pulse width", int'(done), 0);
    endtask

    // R9: input extremes.
    task automatic t_extremes();
        t_convert(0, 1'b0, 0, 1'b0);
        check(int'(rd_data) == 0, "R9 zero", int'(rd_data), 0);
        t_convert(1, 1'b0, 1, 1'b0);
        check(int'(rd_data) == 0, "R9 half step", int'(rd_data), 0);
        t_convert(2, 1'b0, 2, 1'b0);
        check(int'(rd_data) == 1, "R9 first code", int'(rd_data), 1);
        t_convert(2046, 1'b0, 3, 1'b0);
        check(int'(rd_data) == 1023, "R9 top", int'(rd_data), 1023);
        t_convert(3000, 1'b1, 4, 1'b0);
        check(int'(rd_data) == 1020, "R9 top short", int'(rd_data), 1020);
    endtask

    // R5: every channel written with a distinct value, others kept.
    task automatic t_channels();
        for (int c = 0; c < 8; c++) begin
            t_convert(200 + 230 * c, c[0], c, 1'b0);
        end
        check_all_channels("R5 channel isolation");
    endtask

    // R7: trigger during a run is ignored.
    task automatic t_ignore();
        t_convert(1333, 1'b0, 6, 1'b1);
        check_all_channels("R7 other channel kept");
        t_convert(777, 1'b1, 2, 1'b1);
        check_all_channels("R7 other channel kept short");
    endtask

    // R8: reset in the middle of a run.
    task automatic t_reset_mid();
        @(negedge clk);
        vin_h = 1500;
        chan = 3'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        repeat (12) @(negedge clk);
        check(done == 1'b0, "R8 no late done", int'(done), 0);
        check_all_channels("R8 mid-run reset");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(601, 1'b0, 0, 1'b0);
        t_convert(1025, 1'b0, 1, 1'b0);
        t_convert(999, 1'b1, 2, 1'b0);
        t_convert(601, 1'b1, 3, 1'b0);
        t_extremes();
        t_channels();
        t_ignore();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule